// File: doc/BRIEF.md
# Immediate-AND Read-Modify-Write Unit

This unit executes one instruction family of a processor with 4-bit data: AND a 4-bit immediate into a data nibble addressed through an index register. It decodes a 13-bit opcode and selects index X or Y. It then reads the addressed nibble from a synchronous memory, ANDs it with the immediate, and writes the result back to the same address. It also computes the new flag values. When the opcode requests it, it also supplies the incremented index value so that the surrounding register file can store it.

An extension mode is controlled by an extension flag and an 8-bit extension value, both supplied by the caller. In the plain form with the flag set, the address is forced into a 256-nibble page. X-based accesses go to the bottom page (0000H upward). Y-based accesses go to the top page (FF00H upward). The post-increment form ignores the extension and always addresses through the index register.

The control is a four-state machine:
- IDLE waits for `start`.
- READ presents the address.
- WRITE stores the result, drives the flag and index updates, and pulses `done`.
- FAULT lasts one cycle and reports an opcode that is not part of the family.

Transitions:
- IDLE→READ when `start` is high and the opcode is legal.
- IDLE→FAULT when `start` is high and the opcode is illegal.
- READ→WRITE and WRITE→IDLE unconditionally.
- FAULT→IDLE unconditionally.

Top module: `nib_and_rmw`

## Requirements
- R1: An opcode is legal when bits 12..6 equal 1101000b. In a legal opcode, bit 5 picks Y (1) or X (0), bit 4 picks the post-increment form (1), and bits 3..0 are the immediate. `idx_sel_y` reports the bit 5 choice during the write cycle.
- R2: `start` is sampled in IDLE. For a legal opcode the next cycle is the read cycle: `busy` is high and `mem_we` and `done` are low. The cycle after that is the write cycle: `mem_we` and `done` are both high for exactly that one cycle. The unit is idle again in the following cycle.
- R3: In the write cycle, `mem_wdata` equals the nibble read at the selected address ANDed with the immediate. `mem_addr` is identical in the read and write cycles.
- R4: In the write cycle `flags_we` is high and Z (`flags_out[0]`) is 1 exactly when the 4-bit result is zero.
- R5: In the write cycle E (`flags_out[3]`) is 0. I (`flags_out[2]`) and C (`flags_out[1]`) equal `flags_in[2]` and `flags_in[1]`.
- R6: In the plain form with `ext_flag` high and X selected, the address is 0000H plus `ext_val`.
- R7: In the plain form with `ext_flag` high and Y selected, the address is FF00H plus `ext_val`.
- R8: In the post-increment form, `idx_we` is high in the write cycle and `idx_next` equals the selected index value at `start` plus 1, modulo 2^16 (FFFFH gives 0000H). In the plain form `idx_we` stays low. The increment does not influence Z.
- R9: The post-increment form addresses memory through the index register itself even when `ext_flag` is high.
- R10: `start` with an illegal opcode raises `illegal` for exactly the next cycle. No memory, flag or index write occurs, and the unit then returns to idle.
- R11: A synchronous active-high `rst` returns the unit to IDLE, with `mem_we`, `done`, `busy`, `illegal`, `flags_we` and `idx_we` all low.
- R12: Whenever `flags_we` is low, `flags_out` equals `flags_in`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin executing `opcode` (sampled in IDLE) |
| opcode | input | 13 | Instruction word |
| x_in | input | 16 | Index register X |
| y_in | input | 16 | Index register Y |
| ext_flag | input | 1 | Extension prefix active |
| ext_val | input | 8 | Extension value (in-page offset) |
| flags_in | input | 4 | Current flags {E,I,C,Z} |
| mem_addr | output | 16 | Data memory address |
| mem_rdata | input | 4 | Read data, valid one cycle after the address |
| mem_wdata | output | 4 | Write data |
| mem_we | output | 1 | Write enable |
| flags_out | output | 4 | Next flag values {E,I,C,Z} |
| flags_we | output | 1 | Flag update strobe |
| idx_we | output | 1 | Index register update strobe |
| idx_sel_y | output | 1 | Index register to update: 1 = Y, 0 = X |
| idx_next | output | 16 | Incremented index value |
| busy | output | 1 | Instruction in progress |
| done | output | 1 | Completion pulse in the write cycle |
| illegal | output | 1 | Illegal-opcode pulse |

## Verification
A wrong state or a wrong latched operand shows up at the ports no later than the write cycle, two cycles after `start`. There it appears as a mistimed or missing `mem_we`/`done` pulse, a write address that differs from the read address, wrong write data or flags, or an index update in the wrong form. A stuck or skipped state shows one cycle later, because `busy` stays high or `mem_we` repeats. A faulty decode of an illegal opcode is visible in the very next cycle, as a missing `illegal` pulse or a stray write strobe.

// File: rtl/nib_and_pkg.sv
package nib_and_pkg;

    typedef enum logic [1:0] {
        S_IDLE,
        S_READ,
        S_WRITE,
        S_FAULT
    } rmw_state_e;

    // flag vector bit positions {E,I,C,Z}
    localparam int FLG_E = 3;
    localparam int FLG_I = 2;
    localparam int FLG_C = 1;
    localparam int FLG_Z = 0;
    localparam int FLG_W = 4;

endpackage

// File: rtl/nib_and_decode.sv
module nib_and_decode #(
    parameter int OP_W   = 13,
    parameter int DATA_W = 4,
    parameter logic [OP_W-DATA_W-3:0] FAMILY_CODE = 7'b1101000
) (
    input  logic [OP_W-1:0]   opcode,
    output logic              legal,
    output logic              use_y,
    output logic              post_inc,
    output logic [DATA_W-1:0] imm
);
    localparam int FAM_W   = OP_W - DATA_W - 2;
    localparam int SEL_BIT = DATA_W + 1;
    localparam int INC_BIT = DATA_W;

    always_comb begin
        legal    = (opcode[OP_W-1 -: FAM_W] == FAMILY_CODE);
        use_y    = opcode[SEL_BIT];
        post_inc = opcode[INC_BIT];
        imm      = opcode[DATA_W-1:0];
    end
endmodule

// File: rtl/nib_and_agen.sv
module nib_and_agen #(
    parameter int ADDR_W = 16,
    parameter int EXT_W  = 8
) (
    input  logic [ADDR_W-1:0] x_idx,
    input  logic [ADDR_W-1:0] y_idx,
    input  logic              use_y,
    input  logic              post_inc,
    input  logic              ext_on,
    input  logic [EXT_W-1:0]  ext_val,
    output logic [ADDR_W-1:0] addr
);
    localparam int PAGE_W = ADDR_W - EXT_W;

    logic [ADDR_W-1:0] page_addr;
    logic [ADDR_W-1:0] base_addr;

    generate
        if (PAGE_W > 0) begin : g_paged
            always_comb begin
                page_addr = use_y ? {{PAGE_W{1'b1}}, ext_val}
                                  : {{PAGE_W{1'b0}}, ext_val};
            end
        end else begin : g_flat
            always_comb begin
                page_addr = ext_val[ADDR_W-1:0];
            end
        end
    endgenerate

    always_comb begin
        base_addr = use_y ? y_idx : x_idx;
        // extension only applies to the plain (non-increment) form
        addr = (ext_on && !post_inc) ? page_addr : base_addr;
    end
endmodule

// File: rtl/nib_and_alu.sv
module nib_and_alu #(
    parameter int DATA_W = 4
) (
    input  logic [DATA_W-1:0] operand,
    input  logic [DATA_W-1:0] imm,
    output logic [DATA_W-1:0] result,
    output logic              zero
);
    always_comb begin
        result = operand & imm;
        zero   = (result == '0);
    end
endmodule

// File: rtl/nib_and_rmw.sv
module nib_and_rmw
    import nib_and_pkg::*;
#(
    parameter int OP_W   = 13,
    parameter int DATA_W = 4,
    parameter int ADDR_W = 16,
    parameter int EXT_W  = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [OP_W-1:0]   opcode,
    input  logic [ADDR_W-1:0] x_in,
    input  logic [ADDR_W-1:0] y_in,
    input  logic              ext_flag,
    input  logic [EXT_W-1:0]  ext_val,
    input  logic [FLG_W-1:0]  flags_in,
    output logic [ADDR_W-1:0] mem_addr,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic [DATA_W-1:0] mem_wdata,
    output logic              mem_we,
    output logic [FLG_W-1:0]  flags_out,
    output logic              flags_we,
    output logic              idx_we,
    output logic              idx_sel_y,
    output logic [ADDR_W-1:0] idx_next,
    output logic              busy,
    output logic              done,
    output logic              illegal
);
    localparam logic [ADDR_W-1:0] IDX_STEP = {{(ADDR_W-1){1'b0}}, 1'b1};

    rmw_state_e state_q, state_d;

    logic              legal_c, use_y_c, inc_c, accept;
    logic [DATA_W-1:0] imm_c;
    logic [ADDR_W-1:0] addr_c;

    logic [ADDR_W-1:0] addr_q;
    logic [ADDR_W-1:0] base_q;
    logic [DATA_W-1:0] imm_q;
    logic              use_y_q;
    logic              inc_q;

    logic [DATA_W-1:0] res_c;
    logic              zero_c;

    nib_and_decode #(.OP_W(OP_W), .DATA_W(DATA_W)) u_dec (
        .opcode   (opcode),
        .legal    (legal_c),
        .use_y    (use_y_c),
        .post_inc (inc_c),
        .imm      (imm_c)
    );

    nib_and_agen #(.ADDR_W(ADDR_W), .EXT_W(EXT_W)) u_agen (
        .x_idx    (x_in),
        .y_idx    (y_in),
        .use_y    (use_y_c),
        .post_inc (inc_c),
        .ext_on   (ext_flag),
        .ext_val  (ext_val),
        .addr     (addr_c)
    );

    nib_and_alu #(.DATA_W(DATA_W)) u_alu (
        .operand (mem_rdata),
        .imm     (imm_q),
        .result  (res_c),
        .zero    (zero_c)
    );

    assign accept = (state_q == S_IDLE) && start && legal_c;

    // next-state selection
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE: begin
                if (start) state_d = legal_c ? S_READ : S_FAULT;
            end
            S_READ:  state_d = S_WRITE;
            S_WRITE: state_d = S_IDLE;
            S_FAULT: state_d = S_IDLE;
        endcase
    end

    // state and operand registers
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= S_IDLE;
            addr_q  <= '0;
            base_q  <= '0;
            imm_q   <= '0;
            use_y_q <= 1'b0;
            inc_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            if (accept) begin
                addr_q  <= addr_c;
                base_q  <= use_y_c ? y_in : x_in;
                imm_q   <= imm_c;
                use_y_q <= use_y_c;
                inc_q   <= inc_c;
            end
        end
    end

    // outputs per state
    always_comb begin
        mem_addr  = addr_q;
        mem_wdata = res_c;
        mem_we    = 1'b0;
        flags_out = flags_in;
        flags_we  = 1'b0;
        idx_we    = 1'b0;
        idx_sel_y = use_y_q;
        idx_next  = base_q + IDX_STEP;
        busy      = 1'b1;
        done      = 1'b0;
        illegal   = 1'b0;
        unique case (state_q)
            S_IDLE: begin
                busy = 1'b0;
            end
            S_READ: begin
            end
            S_WRITE: begin
                mem_we           = 1'b1;
                done             = 1'b1;
                flags_we         = 1'b1;
                flags_out[FLG_E] = 1'b0;
                flags_out[FLG_Z] = zero_c;
                idx_we           = inc_q;
            end
            S_FAULT: begin
                illegal = 1'b1;
            end
        endcase
    end

endmodule

// File: rtl/nib_and_chk.sv
module nib_and_chk #(
    parameter int DATA_W = 4,
    parameter int ADDR_W = 16
) (
    input logic              clk,
    input logic              rst,
    input logic [ADDR_W-1:0] x_in,
    input logic [ADDR_W-1:0] y_in,
    input logic [3:0]        flags_in,
    input logic [ADDR_W-1:0] mem_addr,
    input logic [DATA_W-1:0] mem_wdata,
    input logic              mem_we,
    input logic [3:0]        flags_out,
    input logic              flags_we,
    input logic              idx_we,
    input logic              idx_sel_y,
    input logic [ADDR_W-1:0] idx_next,
    input logic              done,
    input logic              illegal
);
    // R2
    write_single_chk: assert property (@(posedge clk) disable iff (rst)
        mem_we |=> !mem_we);

    // R2
    done_with_write_chk: assert property (@(posedge clk) disable iff (rst)
        done |-> mem_we);

    // R3
    same_addr_chk: assert property (@(posedge clk) disable iff (rst)
        mem_we |-> (mem_addr == $past(mem_addr)));

    // R4
    zero_flag_chk: assert property (@(posedge clk) disable iff (rst)
        flags_we |-> (flags_out[0] == (mem_wdata == '0)));

    // R5
    flag_keep_chk: assert property (@(posedge clk) disable iff (rst)
        flags_we |-> (!flags_out[3] && flags_out[2:1] == flags_in[2:1]));

    // R8
    idx_inc_chk: assert property (@(posedge clk) disable iff (rst)
        idx_we |-> (idx_next == ADDR_W'((idx_sel_y ? $past(y_in, 2) : $past(x_in, 2)) + 1'b1)));

    // R10
    fault_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        illegal |-> (!mem_we && !flags_we && !idx_we));

    // R12
    flags_pass_chk: assert property (@(posedge clk) disable iff (rst)
        !flags_we |-> (flags_out == flags_in));
endmodule

bind nib_and_rmw nib_and_chk #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .x_in      (x_in),
    .y_in      (y_in),
    .flags_in  (flags_in),
    .mem_addr  (mem_addr),
    .mem_wdata (mem_wdata),
    .mem_we    (mem_we),
    .flags_out (flags_out),
    .flags_we  (flags_we),
    .idx_we    (idx_we),
    .idx_sel_y (idx_sel_y),
    .idx_next  (idx_next),
    .done      (done),
    .illegal   (illegal)
);

// File: tb/sim_nib_and_rmw.sv
`timescale 1ns/1ps
module sim_nib_and_rmw;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic [12:0] opcode = '0;
    logic [15:0] x_in = '0, y_in = '0;
    logic        ext_flag = 1'b0;
    logic [7:0]  ext_val = '0;
    logic [3:0]  flags_in = '0;
    logic [15:0] mem_addr;
    logic [3:0]  mem_rdata = '0;
    logic [3:0]  mem_wdata;
    logic        mem_we;
    logic [3:0]  flags_out;
    logic        flags_we, idx_we, idx_sel_y, busy, done, illegal;
    logic [15:0] idx_next;

    int vectors = 0;
    int fails = 0;
    bit finished = 1'b0;

    logic [3:0] bmem [0:255];

    always #4 clk = ~clk;

    always @(posedge clk) begin
        if (mem_we) bmem[mem_addr[7:0]] <= mem_wdata;
        mem_rdata <= bmem[mem_addr[7:0]];
    end

    nib_and_rmw u0 (
        .clk(clk), .rst(rst), .start(start), .opcode(opcode),
        .x_in(x_in), .y_in(y_in), .ext_flag(ext_flag), .ext_val(ext_val),
        .flags_in(flags_in), .mem_addr(mem_addr), .mem_rdata(mem_rdata),
        .mem_wdata(mem_wdata), .mem_we(mem_we), .flags_out(flags_out),
        .flags_we(flags_we), .idx_we(idx_we), .idx_sel_y(idx_sel_y),
        .idx_next(idx_next), .busy(busy), .done(done), .illegal(illegal)
    );

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        vectors++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic reset_test;
        rst = 1'b1;
        repeat (3) @(negedge clk);
        chk("R11", "mem_we", mem_we, 0);
        chk("R11", "done", done, 0);
        chk("R11", "busy", busy, 0);
        chk("R11", "illegal", illegal, 0);
        chk("R11", "flags_we", flags_we, 0);
        chk("R11", "idx_we", idx_we, 0);
        rst = 1'b0;
        @(negedge clk);
    endtask

    // one legal instruction; addr_tag names the addressing requirement
    task automatic run_op(input string addr_tag, input logic [12:0] op,
                          input logic [15:0] x, input logic [15:0] y,
                          input logic e, input logic [7:0] ev,
                          input logic [3:0] fl, input logic [3:0] pre,
                          input logic [15:0] exp_addr,
                          input logic [15:0] exp_next);
        logic [3:0] res;
        logic       inc;
        res = pre & op[3:0];
        inc = op[4];
        bmem[exp_addr[7:0]] = pre;
        opcode = op; x_in = x; y_in = y; ext_flag = e; ext_val = ev;
        flags_in = fl; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk("R2", "read busy", busy, 1);
        chk("R2", "read mem_we", mem_we, 0);
        chk("R2", "read done", done, 0);
        chk(addr_tag, "read addr", mem_addr, exp_addr);
        @(negedge clk);
        chk("R2", "write mem_we", mem_we, 1);
        chk("R2", "write done", done, 1);
        chk(addr_tag, "write addr", mem_addr, exp_addr);
        chk("R3", "wdata", mem_wdata, res);
        chk("R4", "flags_we", flags_we, 1);
        chk("R4", "Z", flags_out[0], (res == 4'h0));
        chk("R5", "E,I,C", flags_out[3:1], {1'b0, fl[2], fl[1]});
        chk("R1", "idx_sel_y", idx_sel_y, op[5]);
        chk("R8", "idx_we", idx_we, inc);
        if (inc) chk("R8", "idx_next", idx_next, exp_next);
        @(negedge clk);
        chk("R2", "idle busy", busy, 0);
        chk("R2", "idle mem_we", mem_we, 0);
        chk("R3", "stored", bmem[exp_addr[7:0]], res);
        chk("R12", "flags pass", flags_out, fl);
    endtask

    task automatic illegal_test(input logic [12:0] op);
        bmem[8'h50] = 4'h5;
        opcode = op; x_in = 16'h0050; y_in = 16'h0050; ext_flag = 1'b0;
        flags_in = 4'b1011; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk("R10", "illegal", illegal, 1);
        chk("R10", "mem_we", mem_we, 0);
        chk("R10", "flags_we", flags_we, 0);
        chk("R10", "idx_we", idx_we, 0);
        chk("R10", "flags_out", flags_out, 4'b1011);
        @(negedge clk);
        chk("R10", "illegal drop", illegal, 0);
        chk("R10", "busy", busy, 0);
        chk("R10", "mem_we2", mem_we, 0);
        @(negedge clk);
        chk("R10", "mem intact", bmem[8'h50], 4'h5);
    endtask

    task automatic summary;
        if (!finished) begin
            finished = 1'b1;
            $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    endtask

    initial begin
        for (int i = 0; i < 256; i++) bmem[i] = 4'h0;
        reset_test();
        // R1 plain X, nonzero result, I and C kept
        run_op("R1", 13'h1A06, 16'h1234, 16'h0000, 1'b0, 8'h00, 4'b0110, 4'hB, 16'h1234, 16'h0);
        // R4 plain Y giving zero
        run_op("R1", 13'h1A23, 16'h0000, 16'h00C8, 1'b0, 8'h00, 4'b1001, 4'hC, 16'h00C8, 16'h0);
        // R6 extension with X: bottom page
        run_op("R6", 13'h1A0F, 16'h5577, 16'h0000, 1'b1, 8'h3C, 4'b1000, 4'h9, 16'h003C, 16'h0);
        // R7 extension with Y: top page
        run_op("R7", 13'h1A2A, 16'h0000, 16'h1111, 1'b1, 8'h81, 4'b1110, 4'hF, 16'hFF81, 16'h0);
        // R9 post-increment X ignores extension
        run_op("R9", 13'h1A15, 16'h0042, 16'h0000, 1'b1, 8'h99, 4'b1111, 4'h7, 16'h0042, 16'h0043);
        // R8 post-increment Y wraps FFFF to 0000
        run_op("R8", 13'h1A30, 16'h0000, 16'hFFFF, 1'b0, 8'h00, 4'b0000, 4'hF, 16'hFFFF, 16'h0000);
        // R10 just above the family and a foreign opcode
        illegal_test(13'h1A40);
        illegal_test(13'h0A05);
        summary();
    end

    initial begin
        #(8 * 200000);
        fails++;
        $display("FAIL watchdog expired");
        summary();
    end
endmodule